// File: doc/BRIEF.md
# Floating-Point Input Linearizer and Scaler

This block takes a sample made of a signed mantissa and a small exponent and turns it into one linear fixed-point value. It also attenuates that value by one of two programmable amounts. The mantissa is first placed at the top of a wider signed word. That word is then shifted right arithmetically by one total amount. The total is the exponent's contribution plus a scale value.

The exponent may be inverted before use, as set by a polarity bit. Each exponent step moves the value by one or by two bit positions, as set by a weight bit. The scale value comes from one of two 5-bit fields in the control word. A level-indicator pin picks between the two fields, sample by sample. That pin is captured in the same cycle as its mantissa and exponent, so each scale choice belongs to its own sample.

The output stage is a two-state machine. `ST_IDLE` means no sample is presented this cycle, and `ST_EMIT` means a fresh sample is presented. The machine enters `ST_EMIT` from either state on a clock where the input valid is high. It returns to `ST_IDLE` on a clock where the input valid is low. The output data register loads only on a valid input and holds otherwise.

Top module: `fplin_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0 until the first valid sample arrives.
- R2: `out_valid` equals `in_valid` from one clock earlier: a latency of exactly one cycle, with no other gaps or additions.
- R3: When `scale_ctrl[11]` is 1, the exponent is replaced by its 3-bit ones' complement (7 − exponent) before use. When it is 0, the exponent is used as given.
- R4: When `scale_ctrl[10]` is 0, each unit of the effective exponent adds 1 to the right-shift amount.
- R5: When `scale_ctrl[10]` is 1, each unit of the effective exponent adds 2 to the right-shift amount.
- R6: The scale value added to the shift is `scale_ctrl[9:5]` when `in_lvl` is 1, and `scale_ctrl[4:0]` when `in_lvl` is 0.
- R7: For a total shift S below 24, `out_data` equals (mantissa × 4096), taken as a 24-bit signed value, arithmetically shifted right by S. The sign is always preserved.
- R8: For a total shift of 24 or more (up to 45), `out_data` is all ones for a negative mantissa and all zeros otherwise.
- R9: When `in_valid` is 0, `out_data` keeps its previous value, whatever the other inputs do.
- R10: The scale field is chosen by the `in_lvl` value present in the same cycle as the sample, so consecutive samples with alternating `in_lvl` use alternating fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_mant | input | 12 | Signed mantissa |
| in_exp | input | 3 | Exponent code |
| in_lvl | input | 1 | Level indicator; selects the scale field |
| scale_ctrl | input | 12 | [11] exponent polarity, [10] step weight, [9:5] scale while level active, [4:0] scale while level inactive |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed linear sample |

## Verification
The first pattern sweeps every exponent code with both scales at zero, once per weight setting and once with the polarity bit set. This separates a one-bit step from a two-bit step and a plain exponent from an inverted one. The second pattern alternates the level pin on back-to-back samples while the two scale fields differ. This shows that each sample takes its own field and not its neighbour's. The third pattern sets totals of exactly 23, 24 and 45 with positive and negative mantissas, which exposes an off-by-one saturation limit or a lost sign. The last pattern mixes idle cycles that carry changing inputs with a long pseudo-random stream. A behavioural model checks this every clock, which catches any data leak while valid is low and any latency slip.

// File: rtl/fplin_pkg.sv
package fplin_pkg;

    // Output presentation state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fplin_state_e;

    // Exponent step weight, decoded from the weight control bit
    typedef enum logic {
        STEP_ONE = 1'b0,
        STEP_TWO = 1'b1
    } fplin_step_e;

endpackage

// File: rtl/fplin_shift_calc.sv
module fplin_shift_calc
    import fplin_pkg::*;
#(
    parameter int EXP_W   = 3,
    parameter int SCL_W   = 5,
    parameter int SHIFT_W = 6
) (
    input  logic [EXP_W-1:0]     exp_raw,
    input  logic                 lvl,
    input  logic [2*SCL_W+1:0]   ctrl,
    output logic [SHIFT_W-1:0]   shift_amt
);
    localparam int CTRL_W  = 2*SCL_W + 2;
    localparam int POL_BIT = CTRL_W - 1;
    localparam int WGT_BIT = CTRL_W - 2;

    logic [EXP_W-1:0]   exp_eff;
    fplin_step_e        step;
    logic [SHIFT_W-1:0] contrib;
    logic [SCL_W-1:0]   scale_sel;

    always_comb begin
        exp_eff = ctrl[POL_BIT] ? ~exp_raw : exp_raw;
        step    = fplin_step_e'(ctrl[WGT_BIT]);
        unique case (step)
            STEP_ONE: contrib = SHIFT_W'(exp_eff);
            STEP_TWO: contrib = SHIFT_W'({exp_eff, 1'b0});
            default:  contrib = '0;
        endcase
        scale_sel = lvl ? ctrl[2*SCL_W-1:SCL_W] : ctrl[SCL_W-1:0];
        shift_amt = contrib + SHIFT_W'(scale_sel);
    end

endmodule

// File: rtl/fplin_barrel.sv
module fplin_barrel #(
    parameter int IN_W    = 12,
    parameter int OUT_W   = 24,
    parameter int SHIFT_W = 6
) (
    input  logic [IN_W-1:0]    mant,
    input  logic [SHIFT_W-1:0] amt,
    output logic [OUT_W-1:0]   result
);
    localparam int STAGES = $clog2(OUT_W);
    localparam int PAD_W  = OUT_W - IN_W;

    logic signed [OUT_W-1:0] stage [0:STAGES];
    logic                    beyond;

    assign stage[0] = {mant, {PAD_W{1'b0}}};

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            assign stage[k+1] = amt[k] ? (stage[k] >>> (1 << k)) : stage[k];
        end
    endgenerate

    assign beyond = (amt >= SHIFT_W'(OUT_W));
    assign result = beyond ? {OUT_W{mant[IN_W-1]}} : stage[STAGES];

endmodule

// File: rtl/fplin_top.sv
module fplin_top
    import fplin_pkg::*;
#(
    parameter int MANT_W = 12,
    parameter int EXP_W  = 3,
    parameter int SCL_W  = 5,
    parameter int OUT_W  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [MANT_W-1:0]     in_mant,
    input  logic [EXP_W-1:0]      in_exp,
    input  logic                  in_lvl,
    input  logic [2*SCL_W+1:0]    scale_ctrl,
    output logic                  out_valid,
    output logic [OUT_W-1:0]      out_data
);
    localparam int MAX_SHIFT = ((1 << EXP_W) - 1) * 2 + (1 << SCL_W) - 1;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    logic [SHIFT_W-1:0] shift_amt;
    logic [OUT_W-1:0]   shifted;
    logic [OUT_W-1:0]   data_q;
    fplin_state_e       state_q, state_d;

    fplin_shift_calc #(
        .EXP_W  (EXP_W),
        .SCL_W  (SCL_W),
        .SHIFT_W(SHIFT_W)
    ) u_calc (
        .exp_raw  (in_exp),
        .lvl      (in_lvl),
        .ctrl     (scale_ctrl),
        .shift_amt(shift_amt)
    );

    fplin_barrel #(
        .IN_W   (MANT_W),
        .OUT_W  (OUT_W),
        .SHIFT_W(SHIFT_W)
    ) u_barrel (
        .mant  (in_mant),
        .amt   (shift_amt),
        .result(shifted)
    );

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Data register: loads only on a valid sample
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (in_valid) data_q <= shifted;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
        out_data = data_q;
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                       // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                     // R2
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));                              // R9
    AST_SAT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_amt >= SHIFT_W'(OUT_W)) |-> (shifted == {OUT_W{in_mant[MANT_W-1]}})); // R8
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data[OUT_W-1] == $past(in_mant[MANT_W-1])));  // R7

endmodule

// File: tb/tb_fplin_top.sv
module tb_fplin_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_mant = '0;
    logic [2:0]  in_exp = '0;
    logic        in_lvl = 1'b0;
    logic [11:0] scale_ctrl = '0;
    logic        out_valid;
    logic [23:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int exp_valid = 0;
    int exp_data = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    fplin_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
        .in_exp(in_exp), .in_lvl(in_lvl), .scale_ctrl(scale_ctrl),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int model(input int m, input int e, input int lv, input int c);
        int ee, step, sc, tot;
        ee   = ((c >> 11) & 1) != 0 ? (7 - e) : e;
        step = ((c >> 10) & 1) != 0 ? 2 : 1;
        sc   = (lv != 0) ? ((c >> 5) & 31) : (c & 31);
        tot  = ee * step + sc;
        if (tot >= 24) return (m < 0) ? -1 : 0;
        return (m * 4096) >>> tot;
    endfunction

    task automatic compare();
        int act;
        act = int'($signed(out_data));
        checks++;
        if (int'(out_valid) != exp_valid) begin
            errors++;
            $display("FAIL %s valid: actual=%0d expected=%0d", cur_tag, out_valid, exp_valid);
        end
        checks++;
        if (act != exp_data) begin
            errors++;
            $display("FAIL %s data: actual=%0d expected=%0d", cur_tag, act, exp_data);
        end
    endtask

    task automatic cyc(input logic v, input logic [11:0] m, input logic [2:0] e,
                       input logic l, input logic [11:0] c, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; in_mant = m; in_exp = e; in_lvl = l; scale_ctrl = c;
        if (v) begin
            exp_valid = 1;
            exp_data  = model(int'($signed(m)), int'(e), int'(l), int'(c));
        end else begin
            exp_valid = 0;
        end
        cur_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible before any sample
        cur_tag = "R1";
        @(negedge clk);
        compare();
        // R4: one-bit step, exponent sweep
        for (int e = 0; e < 8; e++) cyc(1'b1, 12'h7FF, 3'(e), 1'b0, 12'h000, "R4");
        // R5: two-bit step
        for (int e = 0; e < 8; e++) cyc(1'b1, 12'h800, 3'(e), 1'b0, 12'h400, "R5");
        // R3: inverted exponent, both weights
        for (int e = 0; e < 8; e++) cyc(1'b1, 12'h5A3, 3'(e), 1'b0, 12'h800, "R3");
        for (int e = 0; e < 8; e++) cyc(1'b1, 12'hA5C, 3'(e), 1'b1, 12'hC00, "R3");
        // R6 / R10: alternating level pin, distinct fields (active=9, inactive=2)
        for (int i = 0; i < 8; i++) cyc(1'b1, 12'h733, 3'd1, 1'(i & 1), {2'b00, 5'd9, 5'd2}, "R6");
        for (int i = 0; i < 6; i++) cyc(1'b1, 12'h9C1, 3'd2, 1'(~i & 1), {2'b01, 5'd3, 5'd11}, "R10");
        // R8 / R7 boundaries: totals 23, 24, 45
        cyc(1'b1, 12'h7FF, 3'd0, 1'b0, {2'b00, 5'd0, 5'd23}, "R7");
        cyc(1'b1, 12'h800, 3'd0, 1'b0, {2'b00, 5'd0, 5'd23}, "R7");
        cyc(1'b1, 12'h7FF, 3'd0, 1'b0, {2'b00, 5'd0, 5'd24}, "R8");
        cyc(1'b1, 12'hFFF, 3'd0, 1'b1, {2'b00, 5'd24, 5'd0}, "R8");
        cyc(1'b1, 12'h001, 3'd7, 1'b1, {2'b01, 5'd31, 5'd0}, "R8");
        cyc(1'b1, 12'h801, 3'd7, 1'b1, {2'b01, 5'd31, 5'd0}, "R8");
        cyc(1'b1, 12'h400, 3'd0, 1'b0, {2'b11, 5'd0, 5'd0}, "R8");
        // R9 / R2: idle cycles with changing inputs
        cyc(1'b1, 12'h123, 3'd2, 1'b0, 12'h003, "R9");
        for (int i = 0; i < 5; i++) cyc(1'b0, 12'(i * 391), 3'(i), 1'(i & 1), 12'(i * 257), "R9");
        cyc(1'b1, 12'hE00, 3'd1, 1'b1, 12'h020, "R2");
        cyc(1'b0, 12'h0F0, 3'd0, 1'b0, 12'h000, "R2");
        cyc(1'b1, 12'h0F0, 3'd0, 1'b0, 12'h000, "R2");
        // R7: pseudo-random stream
        for (int i = 0; i < 400; i++)
            cyc(1'(($urandom % 4) != 0), 12'($urandom), 3'($urandom), 1'($urandom),
                12'($urandom), "R7");
        cyc(1'b0, 12'h000, 3'd0, 1'b0, 12'h000, "R2");
        @(negedge clk);
        compare();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule